// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This block is the hazard unit of a five-stage in-order integer pipeline. Each cycle it compares the source register numbers of the instruction held in decode with the destination numbers of the two older instructions in the execute-stage and memory-stage latches. From those comparisons it picks, for each ALU operand, whether the value comes from the register file, from the execute-stage result or from the memory-stage result. The register file writes early in a cycle and reads late in it, so a value that is being written back is already visible to a read, and the unit never selects a writeback path.

A loaded value is not ready in time for the instruction directly behind the load. When the execute stage holds a load whose destination is read by the decode instruction, the unit raises a stall. The stall holds the fetch address register and the fetch/decode latch, and it turns the control bits sent into execute into a bubble. One cycle later the load has moved on to the memory stage and is forwarded from there. The unit is purely combinational and has no clock or reset.

Top module: `hazard_fwd_unit`

## Requirements
- R1: For operand A (source slot 0, bits [AW-1:0] of `id_src`), when `ex_reg_wr` is 1 and `ex_dst` equals that source, `fwd_sel[1:0]` is 2'b01 (execute-stage result).
- R2: Operand B (source slot 1, bits [2*AW-1:AW] of `id_src`) is resolved on its own by the same rules, with its select on `fwd_sel[3:2]`. A match on one operand does not change the other operand's select.
- R3: When the execute-stage latch does not match a source, and `mem_reg_wr` is 1 and `mem_dst` equals that source, the select is 2'b10 (memory-stage result).
- R4: When both the execute-stage and the memory-stage latches match a source, the execute-stage result wins and the select is 2'b01.
- R5: When neither latch matches, or when the matching latch has its write flag low, the select is 2'b00 (register file). The value 2'b11 never appears.
- R6: Register number 0 never matches. A source of 0 always gives select 2'b00 and never causes a stall, even when a latch writes register 0.
- R7: When `ex_is_load` and `ex_reg_wr` are both 1 and `ex_dst` equals a nonzero source of the decode instruction in either slot, `stall` is 1 and `pc_en` and `ifid_en` are both 0. Otherwise `stall` is 0 and both enables are 1.
- R8: While `stall` is 1, `idex_reg_wr` and `idex_mem_wr` are 0. While `stall` is 0, they copy `id_reg_wr` and `id_mem_wr`.
- R9: A load in the memory stage never stalls. It is forwarded with select 2'b10, and a load in execute that matches no source does not stall either.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_src | input | NUM_SRC*AW | Source register numbers of the decode instruction, slot 0 in the low bits |
| id_reg_wr | input | 1 | Register-write control decoded for the decode instruction |
| id_mem_wr | input | 1 | Memory-write control decoded for the decode instruction |
| ex_dst | input | AW | Destination register of the execute-stage instruction |
| ex_reg_wr | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | AW | Destination register of the memory-stage instruction |
| mem_reg_wr | input | 1 | Memory-stage instruction writes a register |
| fwd_sel | output | NUM_SRC*2 | Per-operand select: 00 register file, 01 execute result, 10 memory result |
| stall | output | 1 | Load-use interlock active |
| pc_en | output | 1 | Enable for the fetch address register |
| ifid_en | output | 1 | Enable for the fetch/decode latch |
| idex_reg_wr | output | 1 | Register-write control into execute, cleared for a bubble |
| idex_mem_wr | output | 1 | Memory-write control into execute, cleared for a bubble |

## Verification
The bench runs a subtract followed by three dependent readers. This separates forwarding from execute, forwarding from memory, and the case two instructions further back that must go to the register file. Cases where both latches hold the same destination show the priority rule. Cases where a match has its write flag low show that the write flag gates the match. Cases that reuse register 0 show that register 0 is excluded. Load cases place the consumer directly behind the load, then one slot later, then with no dependency at all, and in either operand slot. These show that the stall and the bubble appear only for a true load-use pair and last exactly one cycle.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

   localparam int SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_REGFILE = 2'b00,
      SEL_EX      = 2'b01,
      SEL_MEM     = 2'b10
   } opnd_sel_e;

endpackage

// File: rtl/hz_dst_match.sv
module hz_dst_match #(
   parameter int AW             = 5,
   parameter bit ZERO_HARDWIRED = 1'b1
) (
   input  logic [AW-1:0] src,
   input  logic [AW-1:0] dst,
   input  logic          wr,
   output logic          hit
);

   logic same;
   assign same = (src == dst);

   generate
      if (ZERO_HARDWIRED) begin : g_zero_excl
         logic src_nonzero;
         assign src_nonzero = |src;
         assign hit = wr & same & src_nonzero;
      end else begin : g_plain
         assign hit = wr & same;
      end
   endgenerate

endmodule

// File: rtl/hz_opnd_sel.sv
module hz_opnd_sel
   import hazard_pkg::*;
#(
   parameter int AW             = 5,
   parameter bit ZERO_HARDWIRED = 1'b1
) (
   input  logic [AW-1:0]    src,
   input  logic [AW-1:0]    ex_dst,
   input  logic             ex_wr,
   input  logic [AW-1:0]    mem_dst,
   input  logic             mem_wr,
   output logic [SEL_W-1:0] sel,
   output logic             ex_hit
);

   logic      mem_hit;
   opnd_sel_e sel_e;

   hz_dst_match #(.AW(AW), .ZERO_HARDWIRED(ZERO_HARDWIRED)) u_ex_cmp (
      .src (src),
      .dst (ex_dst),
      .wr  (ex_wr),
      .hit (ex_hit)
   );

   hz_dst_match #(.AW(AW), .ZERO_HARDWIRED(ZERO_HARDWIRED)) u_mem_cmp (
      .src (src),
      .dst (mem_dst),
      .wr  (mem_wr),
      .hit (mem_hit)
   );

   // The younger result (execute) beats the older one (memory).
   always_comb begin
      if (ex_hit)       sel_e = SEL_EX;
      else if (mem_hit) sel_e = SEL_MEM;
      else              sel_e = SEL_REGFILE;
   end

   assign sel = sel_e;

   always_comb begin
      p_legal_sel_r5: assert (sel != 2'b11)
         else $error("illegal operand select");
      if (sel == SEL_EX) begin
         p_ex_src_r1: assert (ex_wr && (ex_dst == src))
            else $error("execute forward without a writing match");
      end
      if (sel == SEL_MEM) begin
         p_mem_second_r3: assert (mem_wr && (mem_dst == src) && !ex_hit)
            else $error("memory forward while execute matches");
      end
      if (ex_hit && mem_hit) begin
         p_young_wins_r4: assert (sel == SEL_EX)
            else $error("older result chosen over younger");
      end
   end

endmodule

// File: rtl/hz_load_interlock.sv
module hz_load_interlock #(
   parameter int NUM_SRC        = 2,
   parameter bit LOAD_USE_STALL = 1'b1
) (
   input  logic [NUM_SRC-1:0] ex_hit,
   input  logic               ex_is_load,
   output logic               stall
);

   generate
      if (LOAD_USE_STALL) begin : g_interlock
         assign stall = ex_is_load & (|ex_hit);
      end else begin : g_no_interlock
         logic unused_inputs;
         assign unused_inputs = ex_is_load ^ (^ex_hit);
         assign stall = 1'b0 & unused_inputs;
      end
   endgenerate

   always_comb begin
      if (stall) begin
         p_stall_needs_load_r7: assert (ex_is_load && (ex_hit != '0))
            else $error("stall without a matching load");
      end
   end

endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
   import hazard_pkg::*;
#(
   parameter int AW             = 5,
   parameter int NUM_SRC        = 2,
   parameter bit ZERO_HARDWIRED = 1'b1,
   parameter bit LOAD_USE_STALL = 1'b1
) (
   input  logic [NUM_SRC*AW-1:0]    id_src,
   input  logic                     id_reg_wr,
   input  logic                     id_mem_wr,
   input  logic [AW-1:0]            ex_dst,
   input  logic                     ex_reg_wr,
   input  logic                     ex_is_load,
   input  logic [AW-1:0]            mem_dst,
   input  logic                     mem_reg_wr,
   output logic [NUM_SRC*SEL_W-1:0] fwd_sel,
   output logic                     stall,
   output logic                     pc_en,
   output logic                     ifid_en,
   output logic                     idex_reg_wr,
   output logic                     idex_mem_wr
);

   localparam int SRC_BITS = NUM_SRC * AW;

   generate
      if (AW < 1 || AW > 8) begin : g_bad_aw
         $error("AW must lie in 1..8");
      end
      if (NUM_SRC < 1 || NUM_SRC > 4) begin : g_bad_nsrc
         $error("NUM_SRC must lie in 1..4");
      end
   endgenerate

   logic [NUM_SRC-1:0] ex_hit;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SRC; gi++) begin : g_opnd
         hz_opnd_sel #(.AW(AW), .ZERO_HARDWIRED(ZERO_HARDWIRED)) u_sel (
            .src     (id_src[gi*AW +: AW]),
            .ex_dst  (ex_dst),
            .ex_wr   (ex_reg_wr),
            .mem_dst (mem_dst),
            .mem_wr  (mem_reg_wr),
            .sel     (fwd_sel[gi*SEL_W +: SEL_W]),
            .ex_hit  (ex_hit[gi])
         );
      end
   endgenerate

   hz_load_interlock #(.NUM_SRC(NUM_SRC), .LOAD_USE_STALL(LOAD_USE_STALL)) u_lock (
      .ex_hit     (ex_hit),
      .ex_is_load (ex_is_load),
      .stall      (stall)
   );

   // Freeze fetch and turn the decode instruction's effect into a bubble.
   assign pc_en       = ~stall;
   assign ifid_en     = ~stall;
   assign idex_reg_wr = id_reg_wr & ~stall;
   assign idex_mem_wr = id_mem_wr & ~stall;

   always_comb begin
      if (stall) begin
         p_bubble_r8: assert (!idex_reg_wr && !idex_mem_wr && !pc_en && !ifid_en)
            else $error("stall without bubble or freeze");
      end else begin
         p_pass_r8: assert ((idex_reg_wr == id_reg_wr) && (idex_mem_wr == id_mem_wr))
            else $error("controls altered outside a stall");
      end
      if (stall) begin
         p_stall_src_r7: assert (ex_reg_wr && (ex_dst != '0 || !ZERO_HARDWIRED))
            else $error("stall on a non-writing or zero destination");
      end
      for (int k = 0; k < NUM_SRC; k++) begin
         if (ZERO_HARDWIRED && (id_src[k*AW +: AW] == '0)) begin
            p_zero_src_r6: assert (fwd_sel[k*SEL_W +: SEL_W] == SEL_REGFILE)
               else $error("register zero forwarded");
         end
      end
   end

   logic unused_bits;
   assign unused_bits = ^SRC_BITS[0];

endmodule

// File: tb/tb_hazard_fwd_unit.sv
module tb_hazard_fwd_unit;

   localparam int AW = 5;
   localparam int NS = 2;

   logic          clk = 1'b0;
   logic [NS*AW-1:0] id_src;
   logic          id_reg_wr, id_mem_wr;
   logic [AW-1:0] ex_dst, mem_dst;
   logic          ex_reg_wr, ex_is_load, mem_reg_wr;
   logic [NS*2-1:0] fwd_sel;
   logic          stall, pc_en, ifid_en, idex_reg_wr, idex_mem_wr;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   hazard_fwd_unit #(.AW(AW), .NUM_SRC(NS)) dut (
      .id_src      (id_src),
      .id_reg_wr   (id_reg_wr),
      .id_mem_wr   (id_mem_wr),
      .ex_dst      (ex_dst),
      .ex_reg_wr   (ex_reg_wr),
      .ex_is_load  (ex_is_load),
      .mem_dst     (mem_dst),
      .mem_reg_wr  (mem_reg_wr),
      .fwd_sel     (fwd_sel),
      .stall       (stall),
      .pc_en       (pc_en),
      .ifid_en     (ifid_en),
      .idex_reg_wr (idex_reg_wr),
      .idex_mem_wr (idex_mem_wr)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Apply one cycle of pipeline state at the falling edge.
   task automatic drive(int a, int b, int exd, bit exw, bit exl,
                        int memd, bit memw, bit idw, bit idm);
      @(negedge clk);
      id_src     <= {b[AW-1:0], a[AW-1:0]};
      ex_dst     <= exd[AW-1:0];
      ex_reg_wr  <= exw;
      ex_is_load <= exl;
      mem_dst    <= memd[AW-1:0];
      mem_reg_wr <= memw;
      id_reg_wr  <= idw;
      id_mem_wr  <= idm;
      #2;
   endtask

   task automatic expect_sel(string req, int ea, int eb);
      chk(req, "sel_a", int'(fwd_sel[1:0]), ea);
      chk(req, "sel_b", int'(fwd_sel[3:2]), eb);
   endtask

   task automatic expect_lock(string req, bit est, bit idw, bit idm);
      chk(req, "stall", int'(stall), int'(est));
      chk(req, "pc_en", int'(pc_en), int'(!est));
      chk(req, "ifid_en", int'(ifid_en), int'(!est));
      chk("R8", "idex_reg_wr", int'(idex_reg_wr), int'(idw && !est));
      chk("R8", "idex_mem_wr", int'(idex_mem_wr), int'(idm && !est));
   endtask

   task automatic t_idle;
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
      expect_sel("R5", 0, 0);
      expect_lock("R7", 0, 0, 0);
   endtask

   // sub r2 ; and r12,r2,r5 ; or r13,r6,r2 ; add r14,r2,r2
   task automatic t_sub_chain;
      drive(2, 5, 2, 1, 0, 9, 1, 1, 0);
      expect_sel("R1", 1, 0);
      expect_lock("R7", 0, 1, 0);
      drive(6, 2, 12, 1, 0, 2, 1, 1, 0);
      expect_sel("R3", 0, 2);
      drive(2, 2, 13, 1, 0, 12, 1, 1, 0);
      expect_sel("R5", 0, 0);
   endtask

   task automatic t_operand_b;
      drive(7, 9, 9, 1, 0, 7, 1, 1, 1);
      expect_sel("R2", 2, 1);
      expect_lock("R8", 0, 1, 1);
   endtask

   task automatic t_priority;
      drive(4, 4, 4, 1, 0, 4, 1, 1, 0);
      expect_sel("R4", 1, 1);
      drive(3, 8, 8, 1, 0, 3, 1, 1, 0);
      expect_sel("R4", 2, 1);
   endtask

   task automatic t_write_flag_low;
      drive(11, 12, 11, 0, 0, 12, 0, 1, 0);
      expect_sel("R5", 0, 0);
      drive(11, 20, 11, 0, 0, 11, 1, 1, 0);
      expect_sel("R5", 2, 0);
   endtask

   task automatic t_zero_reg;
      drive(0, 0, 0, 1, 1, 0, 1, 1, 1);
      expect_sel("R6", 0, 0);
      expect_lock("R6", 0, 1, 1);
   endtask

   // lw r4 ; and r12,r4,r5 -> one bubble, then memory forward
   task automatic t_load_use;
      drive(4, 5, 4, 1, 1, 1, 1, 1, 1);
      expect_lock("R7", 1, 1, 1);
      drive(4, 5, 0, 0, 0, 4, 1, 1, 1);
      expect_sel("R9", 2, 0);
      expect_lock("R9", 0, 1, 1);
   endtask

   task automatic t_load_use_b;
      drive(6, 17, 17, 1, 1, 6, 1, 0, 1);
      expect_lock("R7", 1, 0, 1);
      expect_sel("R2", 2, 1);
   endtask

   task automatic t_load_no_dep;
      drive(6, 7, 8, 1, 1, 0, 0, 1, 1);
      expect_lock("R9", 0, 1, 1);
      expect_sel("R9", 0, 0);
      drive(9, 10, 9, 0, 1, 0, 0, 1, 0);
      expect_lock("R7", 0, 1, 0);
   endtask

   initial begin : watchdog
      repeat (2000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      id_src = '0; id_reg_wr = 0; id_mem_wr = 0;
      ex_dst = '0; ex_reg_wr = 0; ex_is_load = 0;
      mem_dst = '0; mem_reg_wr = 0;
      t_idle();
      t_sub_chain();
      t_operand_b();
      t_priority();
      t_write_flag_low();
      t_zero_reg();
      t_load_use();
      t_load_use_b();
      t_load_no_dep();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule